// File: doc/BRIEF.md
# Network Interface Control and Status Register Bank

This block is the host-visible register bank of a simple network interface. A host bus presents one request per cycle: a byte offset, an access size of 4 or 8 bytes, a write flag and 64 bits of write data. The bank looks the offset up in a per-slot table. Each slot has a register identity, a declared width and read and write permissions. An access that does not match its slot is refused with a one-cycle error pulse. A refused read returns zero and a refused write changes nothing.

The bank holds a 9-bit configuration word, an 8-bit interrupt status and interrupt mask, and one 64-bit transfer descriptor each for the receive and transmit directions. It also returns build-time constants: copy limits, a packets-per-interrupt limit, FIFO sizes, FIFO watermarks and the station address. The receive and transmit completion words are not stored. They are assembled at read time from live engine status inputs and the bank's own busy flags. Writing a descriptor marks its direction busy until the engine reports that the transfer has finished. A write to the command slot with bit 0 set clears the writable state of the bank.

Top module: `nic_csr_bank`

## Requirements
- R1: Offsets are byte offsets; an access is refused when the offset is not a multiple of 4, is 0x1C, is the upper half (base+4) of any 64-bit register, or is 0x68 or above. A refused access sets `rsp_err` for exactly one cycle, the cycle after the request, with `rsp_rdata` zero, and a refused write leaves every register unchanged.
- R2: An access whose size (4 or 8) differs from the register's width is refused as in R1. The 4-byte registers sit at 0x00 to 0x2C and the 8-byte registers at 0x30, 0x38, 0x40, 0x48, 0x50, 0x58 and 0x60.
- R3: Slot 0x04 (command) is write-only, and a read of it is refused. Slots 0x10 to 0x2C, 0x38, 0x40, 0x50, 0x58 and 0x60 are read-only, and a write to any of them is refused. Slots 0x00, 0x08, 0x0C, 0x30 and 0x48 accept both reads and writes.
- R4: The constant slots return their parameter values: rx copy limit at 0x10, tx copy limit at 0x14, rx packets-per-interrupt at 0x18, rx FIFO bytes at 0x20, tx FIFO bytes at 0x24, rx watermark at 0x28, tx watermark at 0x2C and the 64-bit station address at 0x60.
- R5: The configuration at 0x00 keeps write-data bits [8:0] and reads them back zero-extended. It is also driven on `cfg_out`, where bit 2 is the interrupt enable.
- R6: A write to 0x30 (rx) or 0x48 (tx) stores all 64 data bits, which read back unchanged, and sets that direction's busy flag. A done pulse clears the flag. A descriptor write in the same cycle as that direction's done pulse leaves the flag set.
- R7: Reads of 0x38 and 0x40 both return the rx completion word. Its fields are copy length [19:0], packet kind [22:20] (IP, UDP, TCP from low to high), checksum errors [25:23] in the same order, more-data [29], complete [30], rx busy [31] and FIFO packet count [47:32]. All other bits read as zero.
- R8: Reads of 0x50 and 0x58 both return the tx completion word. Its fields are copy length [19:0], below-watermark [28], FIFO-full [29], complete [30], tx busy [31] and FIFO packet count [47:32]. All other bits read as zero.
- R9: Each bit of `intr_evt` sets the matching interrupt status bit at 0x08. A read of 0x08 returns the status and then clears it. Writing ones to 0x08 clears those bits. An event arriving in the same cycle as a clear stays set.
- R10: `irq` is high exactly when the interrupt enable is set and some status bit is set with its bit in the mask at 0x0C also set.
- R11: A write of 0x04 with data bit 0 set clears the configuration, status, mask, both descriptors, both busy flags and both latched flags in the next cycle. With bit 0 clear, the write has no effect.
- R12: `rx_empty_seen` latches when `intr_evt[2]` pulses and `tx_full_seen` latches when `intr_evt[6]` pulses. They stay set until a reset or a command reset.
- R13: An accepted read sets `rsp_vld` for one cycle, the cycle after the request, with registered `rsp_rdata`. 4-byte registers read zero-extended. A write never produces `rsp_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_vld | input | 1 | bus request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | access size in bytes (4 or 8) |
| req_off | input | 8 | byte offset |
| req_wdata | input | 64 | write data |
| rsp_vld | output | 1 | read data valid |
| rsp_err | output | 1 | access refused |
| rsp_rdata | output | 64 | registered read data |
| rx_done_pulse | input | 1 | rx transfer finished |
| tx_done_pulse | input | 1 | tx transfer finished |
| rx_copy_len | input | 20 | rx bytes copied |
| rx_kind | input | 3 | rx IP/UDP/TCP packet flags |
| rx_csum_err | input | 3 | rx IP/UDP/TCP checksum errors |
| rx_more | input | 1 | rx packet has more data |
| rx_complete | input | 1 | rx data valid |
| rx_fifo_pkts | input | 16 | packets in rx FIFO |
| tx_copy_len | input | 20 | tx bytes copied |
| tx_below_mark | input | 1 | tx FIFO below watermark |
| tx_fifo_full | input | 1 | tx FIFO full |
| tx_complete | input | 1 | tx data valid |
| tx_fifo_pkts | input | 16 | packets in tx FIFO |
| intr_evt | input | 8 | interrupt event pulses |
| cfg_out | output | 9 | configuration word |
| rx_busy | output | 1 | rx descriptor outstanding |
| tx_busy | output | 1 | tx descriptor outstanding |
| rx_empty_seen | output | 1 | latched rx-empty event |
| tx_full_seen | output | 1 | latched tx-full event |
| irq | output | 1 | interrupt request |

## Verification
Two collisions get targeted stimulus. In the first, an interrupt event arrives in the same cycle as a status read that clears the status. The read must return the old value and the next read must show the new bit. In the second, a descriptor write lands in the cycle where that direction's done pulse is high, and the busy flag must stay set afterwards. A scoreboard queue checks every read and refused access, with its data, in the cycle after the request. Checks at the pins confirm that refused writes and a command write with bit 0 clear change no state.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int OFF_W   = 8;
    localparam int DW      = 64;
    localparam int CFG_W   = 9;
    localparam int INTR_W  = 8;
    localparam int NCHAN   = 2;
    localparam int CH_RX   = 0;
    localparam int CH_TX   = 1;
    localparam int CFG_IRQ_EN   = 2;
    localparam int EVT_RX_EMPTY = 2;
    localparam int EVT_TX_FULL  = 6;
    localparam int CMD_CLEAR    = 0;

    typedef enum logic [4:0] {
        SLOT_NONE,
        SLOT_CONFIG,
        SLOT_COMMAND,
        SLOT_ISTAT,
        SLOT_IMASK,
        SLOT_RX_COPY_CAP,
        SLOT_TX_COPY_CAP,
        SLOT_RX_PKT_CAP,
        SLOT_RX_FIFO_BYTES,
        SLOT_TX_FIFO_BYTES,
        SLOT_RX_MARK,
        SLOT_TX_MARK,
        SLOT_RX_DESC,
        SLOT_RX_STAT,
        SLOT_RX_STAT_POLL,
        SLOT_TX_DESC,
        SLOT_TX_STAT,
        SLOT_TX_STAT_POLL,
        SLOT_STATION
    } slot_id_e;

    typedef struct packed {
        slot_id_e   id;
        logic [3:0] width;
        logic       can_rd;
        logic       can_wr;
    } slot_t;

    typedef struct packed {
        logic [15:0] zero_hi;
        logic [15:0] pkts;
        logic        busy;
        logic        complete;
        logic        more;
        logic [2:0]  zero_mid;
        logic [2:0]  csum_err;
        logic [2:0]  kind;
        logic [19:0] len;
    } rx_word_t;

    typedef struct packed {
        logic [15:0] zero_hi;
        logic [15:0] pkts;
        logic        busy;
        logic        complete;
        logic        full;
        logic        low;
        logic [7:0]  zero_mid;
        logic [19:0] len;
    } tx_word_t;

    function automatic slot_t mk_slot(input slot_id_e id, input logic [3:0] w,
                                      input logic r, input logic wr);
        slot_t s;
        s.id = id; s.width = w; s.can_rd = r; s.can_wr = wr;
        return s;
    endfunction

    // index is the byte offset divided by four
    function automatic slot_t slot_lookup(input logic [5:0] idx);
        case (idx)
            6'd0:  return mk_slot(SLOT_CONFIG,        4'd4, 1'b1, 1'b1);
            6'd1:  return mk_slot(SLOT_COMMAND,       4'd4, 1'b0, 1'b1);
            6'd2:  return mk_slot(SLOT_ISTAT,         4'd4, 1'b1, 1'b1);
            6'd3:  return mk_slot(SLOT_IMASK,         4'd4, 1'b1, 1'b1);
            6'd4:  return mk_slot(SLOT_RX_COPY_CAP,   4'd4, 1'b1, 1'b0);
            6'd5:  return mk_slot(SLOT_TX_COPY_CAP,   4'd4, 1'b1, 1'b0);
            6'd6:  return mk_slot(SLOT_RX_PKT_CAP,    4'd4, 1'b1, 1'b0);
            6'd8:  return mk_slot(SLOT_RX_FIFO_BYTES, 4'd4, 1'b1, 1'b0);
            6'd9:  return mk_slot(SLOT_TX_FIFO_BYTES, 4'd4, 1'b1, 1'b0);
            6'd10: return mk_slot(SLOT_RX_MARK,       4'd4, 1'b1, 1'b0);
            6'd11: return mk_slot(SLOT_TX_MARK,       4'd4, 1'b1, 1'b0);
            6'd12: return mk_slot(SLOT_RX_DESC,       4'd8, 1'b1, 1'b1);
            6'd14: return mk_slot(SLOT_RX_STAT,       4'd8, 1'b1, 1'b0);
            6'd16: return mk_slot(SLOT_RX_STAT_POLL,  4'd8, 1'b1, 1'b0);
            6'd18: return mk_slot(SLOT_TX_DESC,       4'd8, 1'b1, 1'b1);
            6'd20: return mk_slot(SLOT_TX_STAT,       4'd8, 1'b1, 1'b0);
            6'd22: return mk_slot(SLOT_TX_STAT_POLL,  4'd8, 1'b1, 1'b0);
            6'd24: return mk_slot(SLOT_STATION,       4'd8, 1'b1, 1'b0);
            default: return mk_slot(SLOT_NONE,        4'd0, 1'b0, 1'b0);
        endcase
    endfunction

    function automatic logic [DW-1:0] pack_rx(input logic [19:0] len, input logic [2:0] kind,
                                              input logic [2:0] err, input logic more,
                                              input logic complete, input logic busy,
                                              input logic [15:0] pkts);
        rx_word_t w;
        w = '0;
        w.len = len; w.kind = kind; w.csum_err = err; w.more = more;
        w.complete = complete; w.busy = busy; w.pkts = pkts;
        return w;
    endfunction

    function automatic logic [DW-1:0] pack_tx(input logic [19:0] len, input logic low,
                                              input logic full, input logic complete,
                                              input logic busy, input logic [15:0] pkts);
        tx_word_t w;
        w = '0;
        w.len = len; w.low = low; w.full = full;
        w.complete = complete; w.busy = busy; w.pkts = pkts;
        return w;
    endfunction

endpackage

// File: rtl/nic_csr_decode.sv
module nic_csr_decode
    import nic_csr_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [3:0]       size,
    input  logic             wr,
    output logic             ok,
    output slot_id_e         id
);
    slot_t slot;

    always_comb begin
        slot = slot_lookup(off[OFF_W-1:2]);
        id   = slot.id;
        ok   = (slot.id != SLOT_NONE) && (off[1:0] == 2'b00) &&
               (size == slot.width) && (wr ? slot.can_wr : slot.can_rd);
    end
endmodule

// File: rtl/nic_csr_chan.sv
module nic_csr_chan
    import nic_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    input  logic          done,
    output logic [DW-1:0] desc,
    output logic          busy
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            desc <= '0;
            busy <= 1'b0;
        end else begin
            if (load) desc <= wdata;
            busy <= (busy & ~done) | load;
        end
    end
endmodule

// File: rtl/nic_csr_intr.sv
module nic_csr_intr
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [INTR_W-1:0] evt,
    input  logic [INTR_W-1:0] stat_clr,
    input  logic              mask_we,
    input  logic [INTR_W-1:0] mask_wdata,
    input  logic              irq_en,
    output logic [INTR_W-1:0] stat,
    output logic [INTR_W-1:0] mask,
    output logic              empty_seen,
    output logic              full_seen,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stat       <= '0;
            mask       <= '0;
            empty_seen <= 1'b0;
            full_seen  <= 1'b0;
        end else begin
            stat <= (stat & ~stat_clr) | evt;
            if (mask_we) mask <= mask_wdata;
            if (evt[EVT_RX_EMPTY]) empty_seen <= 1'b1;
            if (evt[EVT_TX_FULL])  full_seen  <= 1'b1;
        end
    end

    assign irq = irq_en & (|(stat & mask));
endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
    import nic_csr_pkg::*;
#(
    parameter logic [31:0] RX_COPY_CAP   = 32'h0000_0600,
    parameter logic [31:0] TX_COPY_CAP   = 32'h0000_0700,
    parameter logic [31:0] RX_PKT_CAP    = 32'd10,
    parameter logic [31:0] RX_FIFO_BYTES = 32'h0001_0000,
    parameter logic [31:0] TX_FIFO_BYTES = 32'h0000_8000,
    parameter logic [31:0] RX_MARK       = 32'h0000_C000,
    parameter logic [31:0] TX_MARK       = 32'h0000_2000,
    parameter logic [63:0] STATION_ADDR  = 64'h0000_0A1B_2C3D_4E5F
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_vld,
    input  logic         req_wr,
    input  logic [3:0]   req_size,
    input  logic [7:0]   req_off,
    input  logic [63:0]  req_wdata,
    output logic         rsp_vld,
    output logic         rsp_err,
    output logic [63:0]  rsp_rdata,
    input  logic         rx_done_pulse,
    input  logic         tx_done_pulse,
    input  logic [19:0]  rx_copy_len,
    input  logic [2:0]   rx_kind,
    input  logic [2:0]   rx_csum_err,
    input  logic         rx_more,
    input  logic         rx_complete,
    input  logic [15:0]  rx_fifo_pkts,
    input  logic [19:0]  tx_copy_len,
    input  logic         tx_below_mark,
    input  logic         tx_fifo_full,
    input  logic         tx_complete,
    input  logic [15:0]  tx_fifo_pkts,
    input  logic [7:0]   intr_evt,
    output logic [8:0]   cfg_out,
    output logic         rx_busy,
    output logic         tx_busy,
    output logic         rx_empty_seen,
    output logic         tx_full_seen,
    output logic         irq
);
    localparam int PAD32 = DW - 32;

    logic        acc_ok;
    slot_id_e    acc_id;
    logic        rd_hit, wr_hit, bad_acc, cmd_clear;
    logic [CFG_W-1:0]  cfg_q;
    logic [INTR_W-1:0] istat, imask, istat_clr;
    logic [DW-1:0]     rd_word, rx_word, tx_word;
    logic [NCHAN-1:0]  ch_load, ch_done, ch_busy;
    logic [DW-1:0]     ch_desc [NCHAN];

    nic_csr_decode u_dec (
        .off (req_off),
        .size(req_size),
        .wr  (req_wr),
        .ok  (acc_ok),
        .id  (acc_id)
    );

    assign rd_hit    = req_vld & acc_ok & ~req_wr;
    assign wr_hit    = req_vld & acc_ok & req_wr;
    assign bad_acc   = req_vld & ~acc_ok;
    assign cmd_clear = wr_hit && (acc_id == SLOT_COMMAND) && req_wdata[CMD_CLEAR];

    // descriptor channels, index 0 receive, 1 transmit
    assign ch_load[CH_RX] = wr_hit && (acc_id == SLOT_RX_DESC);
    assign ch_load[CH_TX] = wr_hit && (acc_id == SLOT_TX_DESC);
    assign ch_done[CH_RX] = rx_done_pulse;
    assign ch_done[CH_TX] = tx_done_pulse;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        nic_csr_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .clr  (cmd_clear),
            .load (ch_load[c]),
            .wdata(req_wdata),
            .done (ch_done[c]),
            .desc (ch_desc[c]),
            .busy (ch_busy[c])
        );
    end

    assign rx_busy = ch_busy[CH_RX];
    assign tx_busy = ch_busy[CH_TX];

    always_comb begin
        istat_clr = '0;
        if (rd_hit && acc_id == SLOT_ISTAT) istat_clr = '1;
        else if (wr_hit && acc_id == SLOT_ISTAT) istat_clr = req_wdata[INTR_W-1:0];
    end

    nic_csr_intr u_intr (
        .clk       (clk),
        .rst       (rst),
        .clr       (cmd_clear),
        .evt       (intr_evt),
        .stat_clr  (istat_clr),
        .mask_we   (wr_hit && acc_id == SLOT_IMASK),
        .mask_wdata(req_wdata[INTR_W-1:0]),
        .irq_en    (cfg_q[CFG_IRQ_EN]),
        .stat      (istat),
        .mask      (imask),
        .empty_seen(rx_empty_seen),
        .full_seen (tx_full_seen),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd_clear) cfg_q <= '0;
        else if (wr_hit && acc_id == SLOT_CONFIG) cfg_q <= req_wdata[CFG_W-1:0];
    end
    assign cfg_out = cfg_q;

    // completion words built live from engine state
    assign rx_word = pack_rx(rx_copy_len, rx_kind, rx_csum_err, rx_more,
                             rx_complete, ch_busy[CH_RX], rx_fifo_pkts);
    assign tx_word = pack_tx(tx_copy_len, tx_below_mark, tx_fifo_full,
                             tx_complete, ch_busy[CH_TX], tx_fifo_pkts);

    always_comb begin
        case (acc_id)
            SLOT_CONFIG:        rd_word = {{(DW-CFG_W){1'b0}}, cfg_q};
            SLOT_ISTAT:         rd_word = {{(DW-INTR_W){1'b0}}, istat};
            SLOT_IMASK:         rd_word = {{(DW-INTR_W){1'b0}}, imask};
            SLOT_RX_COPY_CAP:   rd_word = {{PAD32{1'b0}}, RX_COPY_CAP};
            SLOT_TX_COPY_CAP:   rd_word = {{PAD32{1'b0}}, TX_COPY_CAP};
            SLOT_RX_PKT_CAP:    rd_word = {{PAD32{1'b0}}, RX_PKT_CAP};
            SLOT_RX_FIFO_BYTES: rd_word = {{PAD32{1'b0}}, RX_FIFO_BYTES};
            SLOT_TX_FIFO_BYTES: rd_word = {{PAD32{1'b0}}, TX_FIFO_BYTES};
            SLOT_RX_MARK:       rd_word = {{PAD32{1'b0}}, RX_MARK};
            SLOT_TX_MARK:       rd_word = {{PAD32{1'b0}}, TX_MARK};
            SLOT_RX_DESC:       rd_word = ch_desc[CH_RX];
            SLOT_TX_DESC:       rd_word = ch_desc[CH_TX];
            SLOT_RX_STAT,
            SLOT_RX_STAT_POLL:  rd_word = rx_word;
            SLOT_TX_STAT,
            SLOT_TX_STAT_POLL:  rd_word = tx_word;
            SLOT_STATION:       rd_word = STATION_ADDR;
            default:            rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_vld   <= rd_hit;
            rsp_err   <= bad_acc;
            rsp_rdata <= rd_hit ? rd_word : '0;
        end
    end
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_vld,
    input logic        req_wr,
    input logic [3:0]  req_size,
    input logic [7:0]  req_off,
    input logic        req_wd0,
    input logic        rsp_vld,
    input logic        rsp_err,
    input logic [63:0] rsp_rdata,
    input logic        rx_done_pulse,
    input logic [7:0]  intr_evt,
    input logic        rx_busy,
    input logic        rx_empty_seen,
    input logic        cfg_irq_en,
    input logic        irq
);
    logic cmd_wr, rx_desc_wr;
    assign cmd_wr     = req_vld && req_wr && req_off == 8'h04 && req_size == 4'd4 && req_wd0;
    assign rx_desc_wr = req_vld && req_wr && req_off == 8'h30 && req_size == 4'd8;

    a_r1_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_rdata == 64'd0);
    a_r1_err_after_req: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $past(req_vld));
    a_r13_vld_after_read: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> $past(req_vld && !req_wr));
    a_r13_vld_err_apart: assert property (@(posedge clk) disable iff (rst)
        !(rsp_vld && rsp_err));
    a_r6_busy_on_write: assert property (@(posedge clk) disable iff (rst)
        rx_desc_wr |=> rx_busy);
    a_r6_busy_drop_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_busy) |-> ($past(rx_done_pulse) || $past(cmd_wr)));
    a_r12_empty_latch: assert property (@(posedge clk) disable iff (rst)
        (intr_evt[2] && !cmd_wr) |=> rx_empty_seen);
    a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
        irq |-> cfg_irq_en);
endmodule

bind nic_csr_bank nic_csr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_vld      (req_vld),
    .req_wr       (req_wr),
    .req_size     (req_size),
    .req_off      (req_off),
    .req_wd0      (req_wdata[0]),
    .rsp_vld      (rsp_vld),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .rx_done_pulse(rx_done_pulse),
    .intr_evt     (intr_evt),
    .rx_busy      (rx_busy),
    .rx_empty_seen(rx_empty_seen),
    .cfg_irq_en   (cfg_out[2]),
    .irq          (irq)
);

// File: tb/nic_csr_bank_tb_top.sv
module nic_csr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 0, req_wr = 0;
    logic [3:0]  req_size = 0;
    logic [7:0]  req_off = 0;
    logic [63:0] req_wdata = 0;
    logic        rsp_vld, rsp_err;
    logic [63:0] rsp_rdata;
    logic        rx_done_pulse = 0, tx_done_pulse = 0;
    logic [19:0] rx_copy_len = 0, tx_copy_len = 0;
    logic [2:0]  rx_kind = 0, rx_csum_err = 0;
    logic        rx_more = 0, rx_complete = 0;
    logic [15:0] rx_fifo_pkts = 0, tx_fifo_pkts = 0;
    logic        tx_below_mark = 0, tx_fifo_full = 0, tx_complete = 0;
    logic [7:0]  intr_evt = 0;
    logic [8:0]  cfg_out;
    logic        rx_busy, tx_busy, rx_empty_seen, tx_full_seen, irq;

    localparam logic [63:0] MAC = 64'h0000_0A1B_2C3D_4E5F;

    always #10 clk = ~clk;

    nic_csr_bank dut_i (.*);

    typedef struct {
        logic        err;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   nchk = 0;
    int   nbad = 0;
    bit   finished = 0;

    function automatic logic [63:0] rx_exp(input logic [19:0] len, input logic [2:0] k,
            input logic [2:0] e, input logic m, input logic c, input logic b, input logic [15:0] p);
        return {16'h0, p, b, c, m, 3'b000, e, k, len};
    endfunction

    function automatic logic [63:0] tx_exp(input logic [19:0] len, input logic lo,
            input logic fu, input logic c, input logic b, input logic [15:0] p);
        return {16'h0, p, b, c, fu, lo, 8'h00, len};
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // driver: called at a negedge, one request per cycle
    task automatic acc(input logic wr, input logic [3:0] sz, input logic [7:0] off,
                       input logic [63:0] wd, input logic experr, input logic [63:0] exp,
                       input string tag);
        exp_t e;
        if (experr || !wr) begin
            e.err = experr; e.data = experr ? 64'd0 : exp; e.tag = tag;
            sb.push_back(e);
        end
        req_vld = 1; req_wr = wr; req_size = sz; req_off = off; req_wdata = wd;
        @(negedge clk);
        req_vld = 0; req_wr = 0;
    endtask

    task automatic rd(input logic [3:0] sz, input logic [7:0] off, input logic [63:0] exp,
                      input string tag);
        acc(1'b0, sz, off, 64'd0, 1'b0, exp, tag);
    endtask

    task automatic bad(input logic wr, input logic [3:0] sz, input logic [7:0] off,
                       input string tag);
        acc(wr, sz, off, 64'd0, 1'b1, 64'd0, tag);
    endtask

    task automatic wr(input logic [3:0] sz, input logic [7:0] off, input logic [63:0] d);
        acc(1'b1, sz, off, d, 1'b0, 64'd0, "");
    endtask

    task automatic evt(input logic [7:0] v);
        intr_evt = v;
        @(negedge clk);
        intr_evt = 0;
    endtask

    // monitor: compares responses against the queue
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            if (rsp_vld || rsp_err) begin
                if (sb.size() == 0) begin
                    nchk++; nbad++;
                    $display("FAIL R13 unexpected response act=%b/%b exp=none", rsp_vld, rsp_err);
                end else begin
                    cur = sb.pop_front();
                    nchk++;
                    if (rsp_err !== cur.err || rsp_vld !== !cur.err || rsp_rdata !== cur.data) begin
                        nbad++;
                        $display("FAIL %s act=err%b/%h exp=err%b/%h",
                                 cur.tag, rsp_err, rsp_rdata, cur.err, cur.data);
                    end
                end
            end else if (sb.size() != 0) begin
                cur = sb.pop_front();
                nchk++; nbad++;
                $display("FAIL %s act=no response exp=err%b/%h", cur.tag, cur.err, cur.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++; nbad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({63'd0, rsp_vld}, 64'd0, "R13 reset rsp_vld");
        chk({55'd0, cfg_out}, 64'd0, "R5 reset cfg");
        chk({63'd0, irq}, 64'd0, "R10 reset irq");

        // R5 configuration
        wr(4'd4, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        chk({55'd0, cfg_out}, 64'h1FF, "R5 cfg_out");
        chk({63'd0, rsp_vld}, 64'd0, "R13 no response to write");
        rd(4'd4, 8'h00, 64'h1FF, "R5 cfg readback");

        // R2 size mismatch
        bad(1'b1, 4'd8, 8'h00, "R2 cfg wide write");
        chk({55'd0, cfg_out}, 64'h1FF, "R2 refused write kept cfg");
        bad(1'b0, 4'd4, 8'h30, "R2 desc narrow read");

        // R1 holes and range
        bad(1'b0, 4'd4, 8'h1C, "R1 hole 0x1C");
        bad(1'b0, 4'd4, 8'h34, "R1 upper half 0x34");
        bad(1'b0, 4'd8, 8'h34, "R1 upper half 0x34 wide");
        bad(1'b0, 4'd4, 8'h02, "R1 misaligned");
        bad(1'b0, 4'd8, 8'h68, "R1 end of space");
        bad(1'b0, 4'd4, 8'hFC, "R1 far offset");
        bad(1'b1, 4'd4, 8'h64, "R1 write upper half");
        rd(4'd8, 8'h60, MAC, "R1 station unchanged");

        // R3 permissions
        bad(1'b0, 4'd4, 8'h04, "R3 read command");
        bad(1'b1, 4'd4, 8'h10, "R3 write copy cap");
        bad(1'b1, 4'd8, 8'h38, "R3 write rx status");
        bad(1'b1, 4'd8, 8'h60, "R3 write station");

        // R4 constants
        rd(4'd4, 8'h10, 64'h600, "R4 rx copy cap");
        rd(4'd4, 8'h14, 64'h700, "R4 tx copy cap");
        rd(4'd4, 8'h18, 64'd10, "R4 rx pkt cap");
        rd(4'd4, 8'h20, 64'h1_0000, "R4 rx fifo bytes");
        rd(4'd4, 8'h24, 64'h8000, "R4 tx fifo bytes");
        rd(4'd4, 8'h28, 64'hC000, "R4 rx mark");
        rd(4'd4, 8'h2C, 64'h2000, "R4 tx mark");

        // R6 descriptors and busy
        wr(4'd8, 8'h30, 64'hC123_4567_89AB_CDEF);
        chk({62'd0, rx_busy, tx_busy}, 64'h2, "R6 rx busy set");
        rd(4'd8, 8'h30, 64'hC123_4567_89AB_CDEF, "R6 rx desc readback");
        rx_done_pulse = 1; @(negedge clk); rx_done_pulse = 0;
        chk({63'd0, rx_busy}, 64'd0, "R6 rx busy cleared");
        wr(4'd8, 8'h48, 64'hFEDC_BA98_7654_3210);
        chk({63'd0, tx_busy}, 64'd1, "R6 tx busy set");
        rd(4'd8, 8'h48, 64'hFEDC_BA98_7654_3210, "R6 tx desc readback");
        tx_done_pulse = 1; @(negedge clk); tx_done_pulse = 0;
        chk({63'd0, tx_busy}, 64'd0, "R6 tx busy cleared");
        rx_done_pulse = 1;
        wr(4'd8, 8'h30, 64'h0000_0011_2233_4455);
        rx_done_pulse = 0;
        chk({63'd0, rx_busy}, 64'd1, "R6 write beats done");

        // R7 rx completion word
        rx_copy_len = 20'h12345; rx_kind = 3'b101; rx_csum_err = 3'b010;
        rx_more = 1; rx_complete = 1; rx_fifo_pkts = 16'h0007;
        rd(4'd8, 8'h38, rx_exp(20'h12345, 3'b101, 3'b010, 1, 1, 1, 16'h7), "R7 rx status");
        rd(4'd8, 8'h40, rx_exp(20'h12345, 3'b101, 3'b010, 1, 1, 1, 16'h7), "R7 rx poll");
        rx_done_pulse = 1; @(negedge clk); rx_done_pulse = 0;
        rx_copy_len = 20'hFFFFF; rx_kind = 3'b011; rx_csum_err = 0;
        rx_more = 0; rx_complete = 0; rx_fifo_pkts = 16'hFFFF;
        rd(4'd8, 8'h38, rx_exp(20'hFFFFF, 3'b011, 3'b000, 0, 0, 0, 16'hFFFF), "R7 rx status idle");

        // R8 tx completion word
        tx_copy_len = 20'h00ABC; tx_below_mark = 1; tx_fifo_full = 0;
        tx_complete = 1; tx_fifo_pkts = 16'd3;
        rd(4'd8, 8'h50, tx_exp(20'h00ABC, 1, 0, 1, 0, 16'd3), "R8 tx status");
        wr(4'd8, 8'h48, 64'h1);
        tx_below_mark = 0; tx_fifo_full = 1;
        rd(4'd8, 8'h58, tx_exp(20'h00ABC, 0, 1, 1, 1, 16'd3), "R8 tx poll busy");

        // R9 interrupt status
        evt(8'h05);
        rd(4'd4, 8'h08, 64'h05, "R9 status read");
        rd(4'd4, 8'h08, 64'h00, "R9 cleared by read");
        intr_evt = 8'h10;
        rd(4'd4, 8'h08, 64'h00, "R9 read during event");
        intr_evt = 0;
        rd(4'd4, 8'h08, 64'h10, "R9 event survives clear");
        evt(8'h0F);
        wr(4'd4, 8'h08, 64'h13);
        rd(4'd4, 8'h08, 64'h0C, "R9 write-one clear");

        // R10 irq and R12 latches
        wr(4'd4, 8'h0C, 64'h00);
        evt(8'h04);
        chk({63'd0, irq}, 64'd0, "R10 masked");
        chk({62'd0, rx_empty_seen, tx_full_seen}, 64'h2, "R12 rx empty latched");
        wr(4'd4, 8'h0C, 64'h04);
        chk({63'd0, irq}, 64'd1, "R10 unmasked");
        rd(4'd4, 8'h0C, 64'h04, "R10 mask readback");
        wr(4'd4, 8'h00, 64'h1FB);
        chk({63'd0, irq}, 64'd0, "R10 enable off");
        wr(4'd4, 8'h00, 64'h1FF);
        chk({63'd0, irq}, 64'd1, "R10 enable on");
        evt(8'h40);
        chk({62'd0, rx_empty_seen, tx_full_seen}, 64'h3, "R12 tx full latched");
        @(negedge clk);
        chk({62'd0, rx_empty_seen, tx_full_seen}, 64'h3, "R12 latches hold");

        // R11 command reset
        wr(4'd4, 8'h04, 64'hFFFF_FFFE);
        chk({54'd0, irq, cfg_out}, {54'd0, 1'b1, 9'h1FF}, "R11 bit0 clear no effect");
        chk({63'd0, tx_busy}, 64'd1, "R11 bit0 clear keeps busy");
        wr(4'd4, 8'h04, 64'h1);
        chk({55'd0, cfg_out}, 64'd0, "R11 cfg cleared");
        chk({59'd0, irq, rx_busy, tx_busy, rx_empty_seen, tx_full_seen}, 64'd0, "R11 flags cleared");
        rd(4'd4, 8'h08, 64'd0, "R11 status cleared");
        rd(4'd4, 8'h0C, 64'd0, "R11 mask cleared");
        rd(4'd8, 8'h30, 64'd0, "R11 rx desc cleared");
        rd(4'd8, 8'h48, 64'd0, "R11 tx desc cleared");

        repeat (3) @(negedge clk);
        chk(sb.size(), 0, "R13 queue drained");
        finished = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule